// File: doc/BRIEF.md
# Crosspoint Configuration Serial Loader

This block is the control front end of a 16-input, 8-output crosspoint router. It takes configuration from a slow four-wire serial bus made of a serial clock, a data input, a data output and an active-low select. It turns each complete transfer into an update of a 40-bit shadow bank. The bank holds eight 5-bit routing slots, one for each output. Each slot gives the input index that feeds the output and a flag that turns the output off. The routing stage that uses the bank is outside this block.

A format pin picks how a transfer is read. In full-frame format, 40 bits rewrite all eight slots at once. The bit pushed out of the load shift register appears on the data output, so several loaders can be chained on one stream. In patch format, an 8-bit word names one output and rewrites only that slot. All serial pins are oversampled by the much faster system clock through synchronizers. Edges of the serial clock are found in the system-clock domain, so that clock must run at least four times faster than the serial clock.

A transfer starts when select falls. The first rising serial-clock edge after that only arms the receiver. Each later falling edge captures one bit. The transfer ends when select returns high while the serial clock is low. The next rising edge then commits the transfer to the bank, and a one-cycle flag reports every real change of the bank.

Top module: `xbar_cfg_loader`

## Requirements
- R1: While select is high, serial-clock and data activity change nothing: the bank keeps its value, the change flag stays low and the data output is driven low.
- R2: After select falls, a falling serial-clock edge that comes before the first rising edge is not captured; the first bit is taken on the first falling edge after that rising edge.
- R3: In full-frame format (format pin low), bank bit k equals the k-th bit received, counting from 0. Output n therefore uses bank bits 5n+3..5n as its input index (LSB received first) and bank bit 5n+4 as its off flag (1 = off, 0 = on).
- R4: In patch format (format pin high), received bits 0..2 give the output index (LSB first), bits 3..6 give the input index (LSB first) and bit 7 gives the off flag. Only the slot of the named output changes.
- R5: A transfer reaches the bank only on the first rising serial-clock edge after select has returned high. Until then the bank holds its old value.
- R6: In full-frame format, select may stay low past 40 bits. The register keeps shifting, the bank receives the last 40 bits, and after k >= 40 captured bits the data output shows received bit k-40. In patch format the data output stays low.
- R7: An incomplete transfer is discarded: fewer than 40 bits in full-frame format, or any count other than 8 in patch format.
- R8: The change flag is high for exactly one system cycle, in the cycle the bank takes a new value. A commit that leaves the bank unchanged raises no flag.
- R9: After reset every slot holds input 0 with the off flag set (each slot reads 5'b10000), and the change flag and data output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bus clock |
| scs_n_i | input | 1 | Serial bus select, active low |
| sdin_i | input | 1 | Serial data in |
| fmt_patch_i | input | 1 | Format select: 0 full frame, 1 single-slot patch |
| sdout_o | output | 1 | Serial data out for chaining |
| route_bank_o | output | 40 | Shadow bank, slot n at bits 5n+4..5n |
| new_data_o | output | 1 | One-cycle pulse when the bank changes |

## Verification
A fault in the bit counter or the arming state shows at the ports as a dropped or wrongly shifted transfer. The bank then either stays unchanged or receives slots displaced by one bit. This is visible within a few system cycles after the trailing rising edge. A fault in the load shift register shows earlier, on the data output, at the first captured bit past 40 in a chained stream. A wrong change comparison shows as a missing, extra or stretched flag pulse in the commit cycle. The bench's scoreboard catches that cycle directly.

// File: rtl/xcl_pkg.sv
package xcl_pkg;

  // Receiver sequencing: idle, armed-wait, shifting, trailing-edge wait.
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_ARM   = 2'd1,
    RX_SHIFT = 2'd2,
    RX_TAIL  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/xcl_pin_sync.sv
module xcl_pin_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/xcl_shift_rx.sv
module xcl_shift_rx
  import xcl_pkg::*;
#(
  parameter int FRAME_W = 40,
  parameter int WORD_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               din_s,
  input  logic               fmt_s,
  output logic [FRAME_W-1:0] frame_o,
  output logic [WORD_W-1:0]  word_o,
  output logic               commit_full_o,
  output logic               commit_word_o,
  output logic               dout_o
);

  localparam int               CNT_W    = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);

  rx_state_e          state_q, state_d;
  logic               sclk_q;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               fmt_q, fmt_d;
  logic               rise, fall;
  logic               shift_en;
  logic               commit_full_d, commit_word_d;
  logic               commit_full_q, commit_word_q;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;

  // Next-state logic
  always_comb begin
    state_d       = state_q;
    cnt_d         = cnt_q;
    fmt_d         = fmt_q;
    shift_en      = 1'b0;
    commit_full_d = 1'b0;
    commit_word_d = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (!cs_n_s) begin
          state_d = RX_ARM;
          cnt_d   = '0;
          fmt_d   = fmt_s;
        end
      end
      RX_ARM: begin
        if (cs_n_s) begin
          state_d = RX_IDLE;
        end else if (rise) begin
          state_d = RX_SHIFT;
        end
      end
      RX_SHIFT: begin
        if (cs_n_s) begin
          state_d = RX_TAIL;
        end else if (fall) begin
          shift_en = 1'b1;
          if (cnt_q != CNT_FULL) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_TAIL: begin
        if (rise) begin
          state_d       = RX_IDLE;
          commit_full_d = !fmt_q && (cnt_q == CNT_FULL);
          commit_word_d = fmt_q && (cnt_q == CNT_WORD);
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  // Newest bit enters at the top, so after FRAME_W shifts bit 0 sits at index 0.
  assign sr_d = shift_en ? {din_s, sr_q[FRAME_W-1:1]} : sr_q;

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= RX_IDLE;
      sclk_q        <= 1'b0;
      sr_q          <= '0;
      cnt_q         <= '0;
      fmt_q         <= 1'b0;
      commit_full_q <= 1'b0;
      commit_word_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      sclk_q        <= sclk_s;
      cnt_q         <= cnt_d;
      fmt_q         <= fmt_d;
      commit_full_q <= commit_full_d;
      commit_word_q <= commit_word_d;
      if (shift_en) begin
        sr_q <= sr_d;
      end
    end
  end

  assign frame_o       = sr_q;
  assign word_o        = sr_q[FRAME_W-1 -: WORD_W];
  assign commit_full_o = commit_full_q;
  assign commit_word_o = commit_word_q;
  assign dout_o        = (!cs_n_s && !fmt_q &&
                          (state_q == RX_ARM || state_q == RX_SHIFT)) ? sr_q[0] : 1'b0;

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && cs_n_s) |=> $stable(sr_q));

  // R5
  tail_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_TAIL) |=> $stable(sr_q));

endmodule

// File: rtl/xcl_shadow_bank.sv
module xcl_shadow_bank #(
  parameter int N_OUT  = 8,
  parameter int IN_AW  = 4,
  parameter int OUT_AW = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            commit_full_i,
  input  logic                            commit_word_i,
  input  logic [N_OUT*(IN_AW+1)-1:0]      frame_i,
  input  logic [OUT_AW+IN_AW:0]           word_i,
  output logic [N_OUT*(IN_AW+1)-1:0]      bank_o,
  output logic                            new_data_o
);

  localparam int               SLOT_W   = IN_AW + 1;
  localparam int               FRAME_W  = N_OUT * SLOT_W;
  localparam logic [SLOT_W-1:0] SLOT_RST = {1'b1, {IN_AW{1'b0}}};

  logic [FRAME_W-1:0] bank_q, bank_d;
  logic               new_data_q, new_data_d;
  logic [OUT_AW-1:0]  word_out;
  logic [SLOT_W-1:0]  word_slot;

  assign word_out  = word_i[OUT_AW-1:0];
  assign word_slot = word_i[OUT_AW+IN_AW:OUT_AW];

  for (genvar n = 0; n < N_OUT; n++) begin : g_slot
    always_comb begin
      if (commit_full_i) begin
        bank_d[n*SLOT_W +: SLOT_W] = frame_i[n*SLOT_W +: SLOT_W];
      end else if (commit_word_i && (word_out == OUT_AW'(n))) begin
        bank_d[n*SLOT_W +: SLOT_W] = word_slot;
      end else begin
        bank_d[n*SLOT_W +: SLOT_W] = bank_q[n*SLOT_W +: SLOT_W];
      end
    end
  end

  assign new_data_d = (commit_full_i || commit_word_i) && (bank_d != bank_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q     <= {N_OUT{SLOT_RST}};
      new_data_q <= 1'b0;
    end else begin
      new_data_q <= new_data_d;
      if (commit_full_i || commit_word_i) begin
        bank_q <= bank_d;
      end
    end
  end

  assign bank_o     = bank_q;
  assign new_data_o = new_data_q;

  // R8
  flag_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_data_q |-> (bank_q != $past(bank_q)));

  // R8
  change_raises_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q != $past(bank_q)) |-> new_data_q);

endmodule

// File: rtl/xbar_cfg_loader.sv
module xbar_cfg_loader #(
  parameter int N_OUT       = 8,
  parameter int N_IN        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    sclk_i,
  input  logic                                    scs_n_i,
  input  logic                                    sdin_i,
  input  logic                                    fmt_patch_i,
  output logic                                    sdout_o,
  output logic [N_OUT*($clog2(N_IN)+1)-1:0]       route_bank_o,
  output logic                                    new_data_o
);

  localparam int OUT_AW  = $clog2(N_OUT);
  localparam int IN_AW   = $clog2(N_IN);
  localparam int SLOT_W  = IN_AW + 1;
  localparam int FRAME_W = N_OUT * SLOT_W;
  localparam int WORD_W  = OUT_AW + SLOT_W;

  // Pin order in the synchronizer: {fmt, din, cs_n, sclk}
  logic [3:0]         pins_s;
  logic [FRAME_W-1:0] frame;
  logic [WORD_W-1:0]  word;
  logic               commit_full, commit_word;

  xcl_pin_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0010)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({fmt_patch_i, sdin_i, scs_n_i, sclk_i}),
    .sync_o (pins_s)
  );

  xcl_shift_rx #(
    .FRAME_W(FRAME_W),
    .WORD_W (WORD_W)
  ) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_s       (pins_s[0]),
    .cs_n_s       (pins_s[1]),
    .din_s        (pins_s[2]),
    .fmt_s        (pins_s[3]),
    .frame_o      (frame),
    .word_o       (word),
    .commit_full_o(commit_full),
    .commit_word_o(commit_word),
    .dout_o       (sdout_o)
  );

  xcl_shadow_bank #(
    .N_OUT (N_OUT),
    .IN_AW (IN_AW),
    .OUT_AW(OUT_AW)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_full_i(commit_full),
    .commit_word_i(commit_word),
    .frame_i      (frame),
    .word_i       (word),
    .bank_o       (route_bank_o),
    .new_data_o   (new_data_o)
  );

endmodule

// File: tb/xbar_cfg_loader_tb.sv
module xbar_cfg_loader_tb;

  localparam int HP = 40;  // serial half period in ns

  logic        clk, rst_n;
  logic        sclk, scs_n, sdin, fmt;
  logic        sdout, new_data;
  logic [39:0] bank;

  int          n_checks = 0;
  int          n_errors = 0;
  logic [39:0] model;
  logic [39:0] exp_q[$];

  xbar_cfg_loader u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_i      (sclk),
    .scs_n_i     (scs_n),
    .sdin_i      (sdin),
    .fmt_patch_i (fmt),
    .sdout_o     (sdout),
    .route_bank_o(bank),
    .new_data_o  (new_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: every flag pulse must match the next queued bank (R8).
  always @(negedge clk) begin
    if (rst_n && new_data) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected change pulse", {24'h0, bank}, 64'hdead);
      end else begin
        chk("R8 bank at pulse", {24'h0, bank}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  function automatic logic [39:0] patch(input logic [39:0] b, input logic [7:0] w);
    logic [39:0] r = b;
    r[5*w[2:0] +: 5] = {w[7], w[6:3]};
    return r;
  endfunction

  task automatic expect_bank(input logic [39:0] nb);
    if (nb !== model) begin
      exp_q.push_back(nb);
      model = nb;
    end
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    sclk = 1'b1; #(HP/2); sdin = b; #(HP/2);
    sclk = 1'b0; #HP;
  endtask

  task automatic send(input logic [63:0] bits, input int n, input logic m);
    fmt = m; #HP;
    scs_n = 1'b0; #HP;
    for (int i = 0; i < n; i++) clk_bit(bits[i]);
    scs_n = 1'b1; #HP;
    sclk = 1'b1; #HP; sclk = 1'b0; #HP;
    settle();
  endtask

  task automatic check_state(input string tag);
    chk({tag, " bank"}, {24'h0, bank}, {24'h0, model});
    chk({tag, " pending"}, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic run();
    logic [63:0] f1 = 64'h00_9C_5A_33_E1_4D;
    logic [63:0] f2 = 64'h0000_1234_5678_9ABC;
    logic [7:0]  w;

    // R9 reset state
    model = {8{5'b10000}};
    chk("R9 bank", {24'h0, bank}, {24'h0, model});
    chk("R9 flag", {63'h0, new_data}, 64'd0);
    chk("R9 dout", {63'h0, sdout}, 64'd0);

    // R3 + R5: full frame, bank holds until trailing rising edge
    fmt = 1'b0; #HP;
    scs_n = 1'b0; #HP;
    for (int i = 0; i < 40; i++) clk_bit(f1[i]);
    scs_n = 1'b1; #HP;
    settle();
    chk("R5 bank held before trailing edge", {24'h0, bank}, {24'h0, model});
    expect_bank(f1[39:0]);
    sclk = 1'b1; #HP; sclk = 1'b0; #HP;
    settle();
    check_state("R3 full frame");

    // R4: patch output 5 with input 11, on
    w = {1'b0, 4'b1011, 3'b101};
    expect_bank(patch(model, w));
    send({56'h0, w}, 8, 1'b1);
    check_state("R4 patch out5");

    // R4: patch output 0 with input 3, off
    w = {1'b1, 4'b0011, 3'b000};
    expect_bank(patch(model, w));
    send({56'h0, w}, 8, 1'b1);
    check_state("R4 patch out0");

    // R8: identical patch, no pulse
    send({56'h0, w}, 8, 1'b1);
    check_state("R8 repeat no pulse");

    // R7: short frame, short word, long word
    send(64'hFFFF_FFFF_FFFF_FFFF, 39, 1'b0);
    check_state("R7 39-bit frame");
    send({56'h0, 8'h2E}, 7, 1'b1);
    check_state("R7 7-bit word");
    send({56'h0, 9'h12E}, 9, 1'b1);
    check_state("R7 9-bit word");

    // R2: falling edge before arming rising edge is ignored
    w = {1'b0, 4'b0110, 3'b111};
    expect_bank(patch(model, w));
    fmt = 1'b1; sclk = 1'b1; #HP;
    scs_n = 1'b0; #HP;
    sdin = 1'b1; sclk = 1'b0; #HP;
    for (int i = 0; i < 8; i++) clk_bit(w[i]);
    scs_n = 1'b1; #HP;
    sclk = 1'b1; #HP; sclk = 1'b0; #HP;
    settle();
    check_state("R2 pre-arm fall");

    // R1: activity with select high
    fmt = 1'b0;
    for (int i = 0; i < 10; i++) begin
      sdin = i[0];
      sclk = 1'b1; #HP; sclk = 1'b0; #HP;
      chk("R1 dout low", {63'h0, sdout}, 64'd0);
    end
    fmt = 1'b1;
    for (int i = 0; i < 10; i++) begin
      sdin = ~i[0];
      sclk = 1'b1; #HP; sclk = 1'b0; #HP;
    end
    settle();
    check_state("R1 ignored");

    // R6: patch format keeps dout low while shifting
    fmt = 1'b1; #HP;
    scs_n = 1'b0; #HP;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1);
      chk("R6 dout low in patch", {63'h0, sdout}, 64'd0);
    end
    scs_n = 1'b1; #HP;
    settle();
    chk("R6 no commit without tail", {24'h0, bank}, {24'h0, model});
    expect_bank(patch(model, 8'hFF));
    sclk = 1'b1; #HP; sclk = 1'b0; #HP;
    settle();
    check_state("R6 patch commit");

    // R6: 48-bit chained stream, dout lags by 40
    expect_bank(f2[47:8]);
    fmt = 1'b0; #HP;
    scs_n = 1'b0; #HP;
    for (int i = 0; i < 48; i++) begin
      clk_bit(f2[i]);
      if (i + 1 >= 40) chk("R6 chained dout", {63'h0, sdout}, {63'h0, f2[i+1-40]});
    end
    scs_n = 1'b1; #HP;
    sclk = 1'b1; #HP; sclk = 1'b0; #HP;
    settle();
    check_state("R6 last 40 bits");
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; scs_n = 1'b1; sdin = 1'b0; fmt = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    fork
      run();
      begin
        repeat (150000) @(negedge clk);
        chk("watchdog expired", 64'd1, 64'd0);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule